// File: doc/BRIEF.md
# RTC Prescaler and Tick Rate Selector

This block sits between a 32768 Hz crystal-rate enable and the time-of-day counters of a real-time clock. A 15-stage binary counter advances once per crystal enable. Its full rollover gives a one-cycle 1 Hz strobe that steps the BCD seconds counter downstream. A selectable tap of the same counter gives a periodic tick pulse for software timekeeping.

A 9-bit control register sits behind a plain write-enable / readback port. Bit 0 unlocks the register, and the other bits keep their value until it is set. Bit 3 holds the divider at zero, so software can load a time and release the divider on an exact second boundary. The tick rate comes from a 4-bit code in bits [8:5], or from bit 4, which forces the full crystal rate. The code-to-rate map is not in ascending order. Bits 1 and 2 are reserved test selects: they are stored and read back, and they change nothing.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, `rd_data` reads 0 and neither `tick_pulse` nor `sec_pulse` is high.
- R2: Bit 0 (interface enable) takes the value written to it on every write, whatever its current value.
- R3: A write updates bits [8:1] only if bit 0 is already 1 or the same write sets bit 0. Otherwise bits [8:1] keep their value. With no write, the register does not change.
- R4: While bit 3 is 1, the divider stays at zero and neither pulse fires. After bit 3 is cleared, the first pulse of period P (in crystal enables) follows exactly the P-th enable.
- R5: `sec_pulse` fires once per 32768 crystal enables, in the cycle after the enable that completes the count.
- R6: With bit 4 = 1, `tick_pulse` fires after every crystal enable, whatever the code in bits [8:5].
- R7: With bit 4 = 0, the code in bits [8:5] sets the tick period. Codes 0..3 give 2, 4, 8 and 16 enables. Code 4 gives 256. Code 5 gives 32768 (1 s). Codes 6, 7 and 8 give 32, 64 and 128. Codes 9..14 give 512, 1024, 2048, 4096, 8192 and 16384.
- R8: With bit 4 = 0 and code 15, `tick_pulse` never fires.
- R9: Bits 1 and 2 are stored and read back but do not change the tick or second timing.
- R10: The divider and both pulses keep running while bit 0 is 0.
- R11: Each pulse lasts one system cycle and only follows a cycle in which `clk32_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk32_en | input | 1 | One-cycle enable at the 32768 Hz crystal rate |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 9 | Write data for the control register |
| rd_data | output | 9 | Current control register value |
| sec_pulse | output | 1 | 1 Hz strobe for the BCD time counters |
| tick_pulse | output | 1 | Periodic tick strobe at the selected rate |

## Verification
Each tick code is measured from a known divider phase by releasing the divider reset and then counting crystal enables up to the first pulse and over several periods. This separates a wrong tap, which gives a wrong period, from an off-by-one rollover, which gives a wrong first-pulse index. Fast mode, the undefined code, and the held-in-reset divider are each checked over a run of enables. The result shows whether the override and the gating take priority over the code. Write patterns with the enable bit at 0, already 1, and rising within the same write separate the lock rule from the rule that the enable bit is always writable. A register left locked with a valid code set shows that counting does not depend on the interface enable.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;

    localparam int DIV_STAGES = 15;
    localparam int CODE_W     = 4;
    localparam int STG_W      = $clog2(DIV_STAGES + 1);

    // Field order is the software-visible bit layout, MSB first.
    typedef struct packed {
        logic [CODE_W-1:0] code;      // [8:5] tick rate code
        logic              fast;      // [4]   tick at full crystal rate
        logic              clr;       // [3]   hold divider at zero
        logic              split;     // [2]   reserved, stored only
        logic              test_src;  // [1]   reserved, stored only
        logic              en;        // [0]   interface enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Number of divider stages whose rollover forms the tick period.
    function automatic logic [STG_W-1:0] code_stages(input logic [CODE_W-1:0] c);
        logic [STG_W-1:0] s;
        case (c)
            4'd0:    s = STG_W'(1);
            4'd1:    s = STG_W'(2);
            4'd2:    s = STG_W'(3);
            4'd3:    s = STG_W'(4);
            4'd4:    s = STG_W'(8);
            4'd5:    s = STG_W'(15);
            4'd6:    s = STG_W'(5);
            4'd7:    s = STG_W'(6);
            4'd8:    s = STG_W'(7);
            default: s = STG_W'(c);   // codes 9..14 map to stages 9..14
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_pre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl
);

    typedef struct packed {
        ctrl_t r;
    } st_t;

    st_t st_d, st_q;
    ctrl_t wr_v;

    always_comb begin
        wr_v = ctrl_t'(wr_data);
        st_d = st_q;
        if (wr_en) begin
            if (st_q.r.en || wr_v.en) begin
                st_d.r = wr_v;
            end else begin
                st_d.r.en = wr_v.en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.r;

endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              hold,
    output logic [STAGES-1:0] count,
    output logic              wrap_pulse
);

    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic              wrap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = step && !hold && (&st_q.cnt);
        if (hold)      st_d.cnt = '0;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count      = st_q.cnt;
    assign wrap_pulse = st_q.wrap;

endmodule

// File: rtl/rtc_tick_sel.sv
module rtc_tick_sel
    import rtc_pre_pkg::*;
#(
    parameter int STAGES = DIV_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              hold,
    input  logic              fast,
    input  logic [CODE_W-1:0] code,
    input  logic [STAGES-1:0] count,
    output logic              tick
);

    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    typedef struct packed {
        logic tick;
    } st_t;

    st_t st_d, st_q;
    logic [STG_W-1:0]  n_stg;
    logic [STAGES-1:0] mask;
    logic              hit;

    always_comb begin
        n_stg = code_stages(code);
        mask  = (STAGES'(1) << n_stg) - STAGES'(1);
        if (fast)                   hit = 1'b1;
        else if (code == CODE_NONE) hit = 1'b0;
        else                        hit = ((count & mask) == mask);
        st_d      = st_q;
        st_d.tick = step && !hold && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk32_en,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              sec_pulse,
    output logic              tick_pulse
);

    ctrl_t                 ctrl;
    logic [DIV_STAGES-1:0] div_cnt;

    rtc_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    rtc_divider #(.STAGES(DIV_STAGES)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (clk32_en),
        .hold       (ctrl.clr),
        .count      (div_cnt),
        .wrap_pulse (sec_pulse)
    );

    rtc_tick_sel #(.STAGES(DIV_STAGES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (clk32_en),
        .hold  (ctrl.clr),
        .fast  (ctrl.fast),
        .code  (ctrl.code),
        .count (div_cnt),
        .tick  (tick_pulse)
    );

    assign rd_data = CTRL_W'(ctrl);

endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk32_en,
    input logic       wr_en,
    input logic [8:0] wr_data,
    input logic [8:0] rd_data,
    input logic       sec_pulse,
    input logic       tick_pulse
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (rd_data == 9'd0 && !tick_pulse && !sec_pulse);
        end
    end

    a_r2_enable_writable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[0] == $past(wr_data[0])));

    a_r3_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_data[0] && !wr_data[0]) |=> $stable(rd_data));

    a_r3_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    a_r4_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |=> (!tick_pulse && !sec_pulse));

    a_r6_fast_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !rd_data[3] && clk32_en) |=> tick_pulse);

    a_r8_code15_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[4] && rd_data[8:5] == 4'hF) |=> !tick_pulse);

    a_r11_tick_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |-> $past(clk32_en));

    a_r11_sec_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(clk32_en));

endmodule

bind rtc_prescaler rtc_prescaler_chk u_chk (.*);

// File: tb/tb_rtc_prescaler.sv
module tb_rtc_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       clk32_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       sec_pulse;
    logic       tick_pulse;

    int checks = 0;
    int fails  = 0;
    int en_idx, t_cnt, t_first, s_cnt, s_first, stray;

    always #10 clk = ~clk;

    rtc_prescaler dut (.*);

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Tick period in crystal enables, written from the requirement R7.
    function automatic int exp_period(input int code);
        case (code)
            0: return 2;      1: return 4;     2: return 8;     3: return 16;
            4: return 256;    5: return 32768; 6: return 32;    7: return 64;
            8: return 128;    9: return 512;   10: return 1024; 11: return 2048;
            12: return 4096;  13: return 8192; 14: return 16384;
            default: return 0;
        endcase
    endfunction

    task automatic wr(input logic [8:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clear_counts();
        en_idx = 0; t_cnt = 0; t_first = 0; s_cnt = 0; s_first = 0; stray = 0;
    endtask

    task automatic pulse_en();
        @(negedge clk);
        if (tick_pulse || sec_pulse) stray++;
        clk32_en = 1'b1; en_idx++;
        @(negedge clk);
        clk32_en = 1'b0;
        if (tick_pulse) begin t_cnt++; if (t_first == 0) t_first = en_idx; end
        if (sec_pulse)  begin s_cnt++; if (s_first == 0) s_first = en_idx; end
    endtask

    task automatic measure(input logic [8:0] ctrl, input int n);
        wr(ctrl | 9'h008);
        wr(ctrl);
        clear_counts();
        repeat (n) pulse_en();
    endtask

    task automatic t_reset();
        chk(rd_data, 0, "R1", "register after reset");
        chk(tick_pulse, 0, "R1", "tick after reset");
        chk(sec_pulse, 0, "R1", "sec after reset");
    endtask

    task automatic t_write_lock();
        wr(9'h1FE); chk(rd_data, 0, "R3", "locked write ignored");
        wr(9'h001); chk(rd_data, 9'h001, "R2", "enable set");
        wr(9'h0A3); chk(rd_data, 9'h0A3, "R3", "write while enabled");
        wr(9'h000); chk(rd_data, 9'h000, "R2", "enable cleared");
        wr(9'h1E0); chk(rd_data, 9'h000, "R3", "locked write ignored again");
        wr(9'h1E1); chk(rd_data, 9'h1E1, "R3", "same-write unlock");
    endtask

    task automatic t_fast();
        measure(9'h011, 50);
        chk(t_cnt, 50, "R6", "fast tick count");
        chk(t_first, 1, "R6", "fast first tick");
        chk(s_cnt, 0, "R5", "no sec in short run");
        chk(stray, 0, "R11", "pulses only after enable");
    endtask

    task automatic t_codes();
        int codes[7] = '{0, 1, 3, 4, 6, 9, 12};
        foreach (codes[i]) begin
            int p = exp_period(codes[i]);
            measure(9'((codes[i] << 5) | 1), 2 * p + 1);
            chk(t_first, p, "R7", $sformatf("first tick code %0d", codes[i]));
            chk(t_cnt, 2, "R7", $sformatf("tick count code %0d", codes[i]));
            chk(stray, 0, "R11", $sformatf("stray pulse code %0d", codes[i]));
        end
    endtask

    task automatic t_code15();
        measure(9'h1E1, 300);
        chk(t_cnt, 0, "R8", "code 15 ticks");
    endtask

    task automatic t_hold();
        wr(9'h019);
        clear_counts();
        repeat (100) pulse_en();
        chk(t_cnt, 0, "R4", "ticks while held");
        chk(rd_data, 9'h019, "R4", "hold bit readback");
        wr(9'h011);
        clear_counts();
        repeat (4) pulse_en();
        chk(t_first, 1, "R4", "first tick after release");
    endtask

    task automatic t_reserved();
        measure(9'h017, 20);
        chk(rd_data, 9'h017, "R9", "reserved bits stored");
        chk(t_cnt, 20, "R9", "reserved bits no effect on tick");
        measure(9'h0C7, 64);
        chk(t_cnt, 2, "R9", "reserved bits no effect on coded tick");
    endtask

    task automatic t_disabled_count();
        measure(9'h0C1, 64);
        wr(9'h0C0);
        chk(rd_data, 9'h0C0, "R10", "disabled register value");
        wr(9'h018);
        chk(rd_data, 9'h0C0, "R3", "write ignored while disabled");
        clear_counts();
        repeat (64) pulse_en();
        chk(t_cnt, 2, "R10", "ticks while disabled");
        chk(t_first, 32, "R10", "tick phase while disabled");
        wr(9'h001);
    endtask

    task automatic t_second();
        measure(9'h0A1, 32768);
        chk(s_cnt, 1, "R5", "sec count");
        chk(s_first, 32768, "R5", "sec position");
        chk(t_cnt, 1, "R7", "code 5 tick count");
        chk(t_first, 32768, "R7", "code 5 tick position");
        chk(stray, 0, "R11", "stray pulse in 1 s run");
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_lock();
        t_fast();
        t_codes();
        t_code15();
        t_hold();
        t_reserved();
        t_disabled_count();
        t_second();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule